// File: doc/BRIEF.md
# ADC Result Holding Register with Coherent Byte Read

This block stores the result of an analog-to-digital conversion and presents it to a processor as two byte-wide registers, a low byte and a high byte. Each time the converter reports a finished conversion, the block formats the value into the two-byte word. A select bit chooses the format. Right alignment, the default, places the value at the bottom of the word. Left alignment places the top eight bits in the high byte.

A processor that needs all bits reads the low byte first and then the high byte. The low-byte read locks the pair against hardware updates. The high-byte read unlocks it. A conversion that finishes while the pair is locked is dropped, so both bytes always come from one conversion. The completion flag still pulses for a dropped conversion. With left alignment, a program that only needs eight bits can read the high byte alone and never take the lock.

Top module: `adc_result_hold`

## Requirements
- R1: After reset both byte registers read zero, the completion flag is low and the pair is unlocked.
- R2: With align_left low, a conversion accepted in a cycle shows after the next clock edge as data_hi = value[9:8] zero-extended and data_lo = value[7:0].
- R3: With align_left high, an accepted conversion shows after the next clock edge as data_hi = value[9:2] and data_lo = {value[1:0], 6'b0}. The alignment bit is sampled in the cycle of the completion strobe.
- R4: A read strobe with rd_sel = 0 (low byte) locks the pair from the next cycle. While the pair is locked, a completion changes neither byte.
- R5: A read strobe with rd_sel = 1 (high byte) unlocks the pair. A completion in a later cycle updates both bytes normally.
- R6: done_flag is high for exactly the cycle after each cycle with conv_done high, whether or not the result was kept.
- R7: A high-byte read while the pair is unlocked leaves both bytes unchanged and does not lock the pair.
- R8: A high-byte read and a completion in the same cycle while the pair is locked release the lock, but that completion is discarded.
- R9: A completion in the same cycle as a low-byte read is discarded, and the pair becomes locked.
- R10: With left alignment, repeated high-byte reads with no low-byte read never block updates. Each conversion's top eight bits appear in data_hi.
- R11: Bytes change only in the cycle after an accepted completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_value | input | 10 | Conversion result, valid with conv_done |
| align_left | input | 1 | 1 = left aligned result, 0 = right aligned |
| rd_strobe | input | 1 | Processor read of a result byte |
| rd_sel | input | 1 | Byte read: 0 = low byte, 1 = high byte |
| data_lo | output | 8 | Low result byte |
| data_hi | output | 8 | High result byte |
| done_flag | output | 1 | Completion pulse, one cycle after conv_done |

## Verification
Two pairs of events can fall in the same cycle: a completion with a high-byte read that releases the lock, and a completion with a low-byte read that takes the lock. The bench steers a completion strobe onto exactly those cycles, both in directed cases and in random traffic with frequent reads. In the cycle after, it judges the bytes and the flag against a reference model written from the rules: the completion is dropped, the flag still pulses, and the lock ends up in the new state.

// File: rtl/adc_hold_pkg.sv
package adc_hold_pkg;
  localparam int unsigned RES_W_DEF  = 10;
  localparam int unsigned BYTE_W_DEF = 8;

  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/adc_hold_align.sv
module adc_hold_align #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned PAD_W  = WORD_W - RES_W
) (
  input  logic [RES_W-1:0]  value,
  input  logic              left,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] ext;

  initial begin
    if (RES_W > WORD_W) $error("result wider than two bytes");
  end

  always_comb begin
    ext  = WORD_W'(value);
    word = left ? (ext << PAD_W) : ext;
  end
endmodule

// File: rtl/adc_hold_lock.sv
module adc_hold_lock
  import adc_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic conv_done,
  input  logic rd_strobe,
  input  logic rd_sel,
  output logic wr_en,
  output logic locked
);
  logic lock_q;
  logic rd_low;
  logic rd_high;

  always_comb begin
    rd_low  = rd_strobe && (byte_sel_e'(rd_sel) == SEL_LOW);
    rd_high = rd_strobe && (byte_sel_e'(rd_sel) == SEL_HIGH);
    wr_en   = conv_done && !lock_q && !rd_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (rd_low) begin
      lock_q <= 1'b1;
    end else if (rd_high) begin
      lock_q <= 1'b0;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/adc_hold_regs.sv
module adc_hold_regs #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word,
  input  logic              conv_done,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= conv_done;
      if (wr_en) begin
        lo_q <= word[BYTE_W-1:0];
        hi_q <= word[WORD_W-1:BYTE_W];
      end
    end
  end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_hold_pkg::*;
#(
  parameter int unsigned RES_W  = RES_W_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_value,
  input  logic              align_left,
  input  logic              rd_strobe,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] data_lo,
  output logic [BYTE_W-1:0] data_hi,
  output logic              done_flag
);
  localparam int unsigned WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] fmt_word;
  logic              wr_en;
  logic              lock_state;

  adc_hold_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
    .value (conv_value),
    .left  (align_left),
    .word  (fmt_word)
  );

  adc_hold_lock u_lock (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .rd_strobe (rd_strobe),
    .rd_sel    (rd_sel),
    .wr_en     (wr_en),
    .locked    (lock_state)
  );

  adc_hold_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .word      (fmt_word),
    .conv_done (conv_done),
    .lo_q      (data_lo),
    .hi_q      (data_hi),
    .flag_q    (done_flag)
  );
endmodule

// File: rtl/adc_result_hold_chk.sv
module adc_result_hold_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned PAD_W  = WORD_W - RES_W
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_value,
  input logic              align_left,
  input logic              rd_strobe,
  input logic              rd_sel,
  input logic [BYTE_W-1:0] data_lo,
  input logic [BYTE_W-1:0] data_hi,
  input logic              done_flag,
  input logic              lock_state
);
  logic accept;
  assign accept = conv_done && !lock_state && !(rd_strobe && !rd_sel);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> done_flag);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> !done_flag);
  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (conv_done && lock_state) |=> ($stable(data_lo) && $stable(data_hi)));
  assert_low_read_lock_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !rd_sel) |=> (lock_state && $stable(data_lo) && $stable(data_hi)));
  assert_high_read_free_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && rd_sel) |=> !lock_state);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> ($stable(data_lo) && $stable(data_hi)));
  assert_right_align_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && !align_left) |=> ({data_hi, data_lo} == WORD_W'($past(conv_value))));
  assert_left_align_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && align_left) |=> ({data_hi, data_lo} == (WORD_W'($past(conv_value)) << PAD_W)));
endmodule

bind adc_result_hold adc_result_hold_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_done  (conv_done),
  .conv_value (conv_value),
  .align_left (align_left),
  .rd_strobe  (rd_strobe),
  .rd_sel     (rd_sel),
  .data_lo    (data_lo),
  .data_hi    (data_hi),
  .done_flag  (done_flag),
  .lock_state (lock_state)
);

// File: tb/test_adc_result_hold.sv
module test_adc_result_hold;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_value = '0;
  logic       align_left = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] data_lo;
  logic [7:0] data_hi;
  logic       done_flag;

  int   n_tests = 0;
  int   n_fail = 0;
  bit   finished = 0;

  logic [15:0] word_m = '0;
  logic        flag_m = 1'b0;
  logic        lock_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_hold i_adc_result_hold (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_value(conv_value),
    .align_left(align_left), .rd_strobe(rd_strobe), .rd_sel(rd_sel),
    .data_lo(data_lo), .data_hi(data_hi), .done_flag(done_flag)
  );

  function automatic logic [15:0] fmt(input logic [9:0] v, input logic left);
    return left ? {v, 6'b0} : {6'b0, v};
  endfunction

  task automatic check(input string tag);
    n_tests++;
    if ({data_hi, data_lo} !== word_m || done_flag !== flag_m) begin
      n_fail++;
      $display("FAIL %s: hi=%h lo=%h flag=%b expected hi=%h lo=%h flag=%b",
               tag, data_hi, data_lo, done_flag, word_m[15:8], word_m[7:0], flag_m);
    end
  endtask

  // Inputs are applied at a falling edge, the model advances at the rising edge,
  // and outputs are compared at the following falling edge.
  task automatic step(input logic cd, input logic [9:0] v, input logic al,
                      input logic rs, input logic sel, input string tag);
    conv_done = cd; conv_value = v; align_left = al; rd_strobe = rs; rd_sel = sel;
    @(posedge clk);
    if (cd && !lock_m && !(rs && !sel)) word_m = fmt(v, al);
    flag_m = cd;
    if (rs) lock_m = !sel;
    @(negedge clk);
    conv_done = 1'b0; rd_strobe = 1'b0;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state");

    step(1, 10'h3A5, 0, 0, 0, "R2 right align");
    step(0, 10'h000, 0, 0, 0, "R6 flag falls");
    step(1, 10'h2C7, 1, 0, 0, "R3 left align");
    step(0, 0, 0, 1, 0, "R4 low read locks");
    step(1, 10'h155, 0, 0, 0, "R4 locked conversion lost, R6 flag fires");
    step(0, 0, 0, 1, 1, "R5 high read releases");
    step(1, 10'h0F3, 0, 0, 0, "R5 update after release");
    step(0, 0, 0, 1, 1, "R7 high read unlocked");
    step(1, 10'h201, 0, 0, 0, "R7 still unlocked");
    step(0, 0, 0, 1, 0, "R8 set lock");
    step(1, 10'h3FF, 1, 1, 1, "R8 high read with conversion");
    step(1, 10'h12A, 1, 0, 0, "R8 unlocked after");
    step(1, 10'h099, 0, 1, 0, "R9 conversion with low read");
    step(1, 10'h3C3, 0, 0, 0, "R9 locked after");
    step(0, 0, 0, 1, 1, "R9 release");
    for (int i = 0; i < 6; i++) begin
      logic [9:0] v;
      v = 10'($urandom);
      step(1, v, 1, 0, 0, "R10 left conversion");
      step(0, 0, 1, 1, 1, "R10 high-only read");
      if (data_hi !== v[9:2]) begin
        n_fail++;
        $display("FAIL R10: hi=%h expected %h", data_hi, v[9:2]);
      end
      n_tests++;
    end
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], 10'(r >> 8), r[2], r[3] & r[4], r[5], "R11 random R4 R5 R8 R9");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule